// File: doc/BRIEF.md
# Heartbeat Watchdog Timer

This block watches a processor heartbeat line and pulls an active-low alarm output down when the line stops changing level. Software toggles the line from its main loop. Every change of level, rising or falling, restarts a tick counter. If the counter reaches a parameterised limit before the next change, the alarm falls. It then stays low until the line moves again.

A system reset holds the counter at zero, and timing starts when that reset lifts. A separate flag reports that the heartbeat line is floating or tri-stated; while it is set the watchdog is switched off and cannot expire. A low-supply flag forces the alarm low regardless of the timer. The alarm recovers when that flag clears, unless the timer has already run out. The heartbeat level goes through a two-flop synchroniser before edge detection. Routing the alarm to an interrupt, or back into a reset source, is done outside the block.

Top module: `wdg_heartbeat_monitor`

## Requirements
- R1: After `rst_n` is released, with all other inputs low, `wdo_n` is 1.
- R2: With the heartbeat steady and no other input active, `wdo_n` stays 1 through the first TIMEOUT_TICKS-1 tick pulses after a clear. It falls to 0 on the clock edge that registers tick number TIMEOUT_TICKS.
- R3: A rising change of `hb_level` clears the counter and raises `wdo_n` on the third clock edge after the change. A full TIMEOUT_TICKS of ticks is then needed for the next timeout.
- R4: A falling change of `hb_level` clears the counter in the same way as a rising change.
- R5: After a timeout, `wdo_n` stays 0 for any number of further ticks until the counter is cleared. The counter saturates at the limit and never wraps.
- R6: While `sys_rst` is 1, the counter is held at zero and ticks are ignored, so `wdo_n` is 1 when `low_supply` is 0. Timing starts from zero after `sys_rst` falls.
- R7: While `hb_float` is 1, the counter is held at zero and `wdo_n` never falls because of a timeout, whatever the ticks or heartbeat do.
- R8: When `hb_float` falls, counting restarts from zero, and a full TIMEOUT_TICKS of ticks is needed before `wdo_n` falls.
- R9: `low_supply` = 1 drives `wdo_n` to 0 on the next clock edge. When it clears, `wdo_n` returns to 1 on the next edge if the timer has not expired, and stays 0 if it has.
- R10: A heartbeat pulse lasting one clock period is recognised as a change and clears the counter.
- R11: When a heartbeat change and a tick reach the counter on the same edge, the clear wins and the count ends at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| tick | input | 1 | One-cycle timebase pulse; one count per pulse |
| hb_level | input | 1 | Heartbeat level (asynchronous, synchronised inside) |
| hb_float | input | 1 | 1 when the heartbeat line is floating; disables the watchdog |
| sys_rst | input | 1 | 1 while system reset is asserted; holds the counter clear |
| low_supply | input | 1 | 1 while the supply is below its threshold; forces the alarm low |
| wdo_n | output | 1 | Registered active-low watchdog alarm |

## Verification
The main collision is a synchronised heartbeat edge arriving on the same clock edge as a timebase tick, with the counter one tick short of the limit. The bench times the heartbeat change so that its detected edge lines up with a driven tick. If the tick won, the output would fall at once; if the clear won, a full fresh period must pass. A second overlap puts a low-supply pulse on top of an expired timer, and the bench checks that releasing the supply flag does not hide the timeout.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef struct packed {
        logic meta;
        logic stable;
        logic last;
    } hb_sync_t;

    typedef struct packed {
        logic alarm_n;
    } wdg_out_t;

endpackage

// File: rtl/wdg_edge_sync.sv
module wdg_edge_sync
    import wdg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hb_async,
    output logic hb_change
);

    hb_sync_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.meta   = hb_async;
        sync_d.stable = sync_q.meta;
        sync_d.last   = sync_q.stable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    // either direction of change counts
    assign hb_change = sync_q.stable ^ sync_q.last;

endmodule

// File: rtl/wdg_tick_counter.sv
module wdg_tick_counter #(
    parameter int TIMEOUT_TICKS = 1600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hold_clr,
    input  logic hb_change,
    output logic expired_d
);

    localparam int CNT_W = $clog2(TIMEOUT_TICKS + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_TICKS);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hold_clr || hb_change) begin
            st_d.cnt = '0;
        end else if (tick && (st_q.cnt != LIMIT)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        expired_d = (st_d.cnt == LIMIT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LIMIT); // R5
    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == LIMIT && !hold_clr && !hb_change) |=> (st_q.cnt == LIMIT)); // R5
    AST_HOLD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        hold_clr |=> (st_q.cnt == '0)); // R6
    AST_EDGE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        hb_change |=> (st_q.cnt == '0)); // R11

endmodule

// File: rtl/wdg_heartbeat_monitor.sv
module wdg_heartbeat_monitor
    import wdg_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 1600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hb_level,
    input  logic hb_float,
    input  logic sys_rst,
    input  logic low_supply,
    output logic wdo_n
);

    logic     hb_change;
    logic     expired_d;
    logic     hold_clr;
    wdg_out_t out_d, out_q;

    wdg_edge_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .hb_async  (hb_level),
        .hb_change (hb_change)
    );

    assign hold_clr = sys_rst | hb_float;

    wdg_tick_counter #(
        .TIMEOUT_TICKS (TIMEOUT_TICKS)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .hold_clr  (hold_clr),
        .hb_change (hb_change),
        .expired_d (expired_d)
    );

    always_comb begin
        out_d         = out_q;
        out_d.alarm_n = !(expired_d || low_supply);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '{alarm_n: 1'b1};
        end else begin
            out_q <= out_d;
        end
    end

    assign wdo_n = out_q.alarm_n;

    AST_LOW_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        low_supply |=> !wdo_n); // R9
    AST_FLOAT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (hb_float && !low_supply) |=> wdo_n); // R7
    AST_SYSRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst && !low_supply) |=> wdo_n); // R6

endmodule

// File: tb/sim_wdg_heartbeat_monitor.sv
`timescale 1ns/1ps
module sim_wdg_heartbeat_monitor;

    localparam int T = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic hb = 1'b0;
    logic hb_float = 1'b0;
    logic sys_rst = 1'b0;
    logic low_supply = 1'b0;
    logic wdo_n;

    int checks = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    wdg_heartbeat_monitor #(.TIMEOUT_TICKS(T)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .hb_level   (hb),
        .hb_float   (hb_float),
        .sys_rst    (sys_rst),
        .low_supply (low_supply),
        .wdo_n      (wdo_n)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input logic exp, input string req);
        checks++;
        if (wdo_n !== exp) begin
            fails++;
            $display("FAIL %s: wdo_n actual %b expected %b at %0t", req, wdo_n, exp, $time);
        end
    endtask

    task automatic pulse_tick();
        tick = 1'b1;
        step();
        tick = 1'b0;
    endtask

    // counter assumed at zero: expect high before limit, low from limit on
    task automatic sweep(input string req);
        for (int i = 1; i <= T + 2; i++) begin
            pulse_tick();
            check((i < T) ? 1'b1 : 1'b0, req);
        end
    endtask

    task automatic toggle_and_settle();
        hb = ~hb;
        step(); step(); step();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run hung, actual running expected done");
        summary();
        $finish;
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        check(1'b1, "R1");

        // R2 timeout from reset
        sweep("R2");

        // R5 saturation: many more ticks, stays low
        for (int i = 0; i < 3 * T; i++) begin
            pulse_tick();
            check(1'b0, "R5");
        end

        // R3 rising change clears
        toggle_and_settle();
        check(1'b1, "R3");
        sweep("R3");

        // R4 falling change clears
        toggle_and_settle();
        check(1'b1, "R4");
        sweep("R4");

        // R6 system reset holds clear
        sys_rst = 1'b1;
        step();
        check(1'b1, "R6");
        for (int i = 0; i < 2 * T; i++) begin
            pulse_tick();
            check(1'b1, "R6");
        end
        sys_rst = 1'b0;
        step();
        sweep("R6");

        // R7 floating line disables
        hb_float = 1'b1;
        step();
        check(1'b1, "R7");
        for (int i = 0; i < 3 * T; i++) begin
            pulse_tick();
            check(1'b1, "R7");
        end
        toggle_and_settle();
        check(1'b1, "R7");
        // R8 restart on release; let the heartbeat edge drain first
        hb_float = 1'b0;
        step();
        sweep("R8");

        // R9 low supply without expiry
        toggle_and_settle();
        check(1'b1, "R9");
        low_supply = 1'b1;
        step();
        check(1'b0, "R9");
        low_supply = 1'b0;
        step();
        check(1'b1, "R9");
        // R9 low supply on top of expiry
        for (int i = 0; i < T; i++) pulse_tick();
        check(1'b0, "R9");
        low_supply = 1'b1;
        step();
        check(1'b0, "R9");
        low_supply = 1'b0;
        step();
        check(1'b0, "R9");

        // R10 one-cycle pulse while expired (hb is 0 here)
        hb = 1'b1;
        step();
        hb = 1'b0;
        step(); step(); step();
        check(1'b1, "R10");
        sweep("R10");

        // R11 change and tick on the same edge with count at T-1
        toggle_and_settle();
        for (int i = 0; i < T - 1; i++) pulse_tick();
        check(1'b1, "R11");
        hb = ~hb;
        step(); step();
        tick = 1'b1;
        step();
        tick = 1'b0;
        check(1'b1, "R11");
        sweep("R11");

        summary();
        $finish;
    end

endmodule